// File: doc/BRIEF.md
# Exception Qualification and Vector Unit

This unit sits beside a processor core's completion logic and decides when the core must leave its normal flow for an exception handler, and which handler offset to use. Each cycle it gathers the raw exception sources: reset requests, machine-check causes, the external and system-management interrupt pins, trace conditions, the performance-monitor limit flag, a rising edge of the decrementer's top bit, and an instruction-address breakpoint match. It gates each source with its own machine-state enable bit. Among the qualified sources it chooses one by a fixed priority.

When the state machine is in `ST_IDLE` and at least one source is qualified, it captures the winner's 20-bit vector offset and moves to `ST_TAKE`. In `ST_TAKE` the take strobe is high for exactly one cycle. The machine then moves to `ST_HOLD` and stays there until `exc_ack`. An acknowledge seen in `ST_TAKE` goes straight back to `ST_IDLE`. The vector stays steady from the take cycle until the acknowledge.

Level-sensitive sources are sampled live and are not stored. A decrementer edge is the one source that is stored: it stays pending until it has been taken and acknowledged. Only that acknowledge clears it.

Top module: `exc_vector_unit`

## Requirements
- R1: Any of `hard_rst_req`, `soft_rst_req` or `por_req` selects offset 0x00100. This source needs no enable bit and outranks every other source.
- R2: `dbus_tea`, `mchk_pin` or any bit of `parity_err` selects offset 0x00200, but only while `msr_me` is 1. With `msr_me` at 0 these inputs produce no take.
- R3: `ext_int_pin` with `msr_ee` = 1 selects offset 0x00500. With `msr_ee` = 0 it produces no take.
- R4: `smi_pin` with `msr_ee` = 1 selects offset 0x01400. With `msr_ee` = 0 it produces no take.
- R5: A 0-to-1 change of `dec_msb` while `msr_ee` = 1 selects offset 0x00900 in the next cycle. Holding `dec_msb` high creates no further request.
- R6: A decrementer edge seen while `msr_ee` = 0 stays pending. It is taken once `msr_ee` becomes 1, even if `dec_msb` has dropped by then.
- R7: `pmon_limit_hit` with `pmon_int_en` = 1 selects offset 0x00F00. If `pmon_int_en` is 0 there is no take.
- R8: Offset 0x01300 is selected only when all three of these hold: `iabr_addr` equals `next_ea[31:2]`; `iabr_te` equals `msr_ir`; and `iabr_en` = 1. The low two address bits are ignored.
- R9: `msr_se` = 1, or `branch_done` with `msr_be` = 1, selects offset 0x00D00. `branch_done` without `msr_be` produces no take.
- R10: When several sources qualify together, priority from highest to lowest is: reset, machine check, breakpoint, trace, external, system management, performance monitor, decrementer.
- R11: `exc_take` is high for exactly one cycle. The take appears in the cycle after the qualifying inputs. `exc_vector` holds its value until `exc_ack`. No new take occurs before `exc_ack`.
- R12: An acknowledge clears the pending flag of the taken source only, so a waiting decrementer edge survives another source's acknowledge. Offset 0x00E00 is never produced. After reset `exc_take` is 0 and `exc_vector` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hard_rst_req | input | 1 | Hard reset request |
| soft_rst_req | input | 1 | Soft reset request |
| por_req | input | 1 | Power-on reset request |
| dbus_tea | input | 1 | Transfer-error acknowledge on a data bus transaction |
| mchk_pin | input | 1 | Machine-check pin |
| parity_err | input | PAR_W (3) | Address, data and second-level cache parity errors |
| ext_int_pin | input | 1 | External interrupt pin |
| smi_pin | input | 1 | System management interrupt pin |
| msr_ee | input | 1 | External-interrupt enable |
| msr_me | input | 1 | Machine-check enable |
| msr_se | input | 1 | Single-step trace enable |
| msr_be | input | 1 | Branch trace enable |
| msr_ir | input | 1 | Instruction translation on |
| branch_done | input | 1 | A branch is completing |
| pmon_limit_hit | input | 1 | A performance counter reached its limit |
| pmon_int_en | input | 1 | Performance-monitor interrupt enable |
| dec_msb | input | 1 | Decrementer most significant bit |
| iabr_addr | input | CMP_W (30) | Breakpoint address, upper word-address bits |
| iabr_te | input | 1 | Breakpoint translation tag |
| iabr_en | input | 1 | Breakpoint enable |
| next_ea | input | EA_W (32) | Effective address of the next instruction to complete |
| exc_ack | input | 1 | Acknowledge of the taken exception |
| exc_take | output | 1 | One-cycle take strobe |
| exc_vector | output | VEC_W (20) | Vector offset of the taken exception |

## Verification
The bench builds the unit with its default parameters: a 32-bit effective address, a 30-bit breakpoint compare, three parity inputs and a 20-bit vector. With these values the breakpoint comparison covers the real upper address field. Changing only the low two address bits shows that they are ignored. Changing one compared bit shows that the match is lost. All three parity lines and every priority pair in the table can be driven directly from the ports.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // Cause codes are listed in priority order, highest first.
    typedef enum logic [2:0] {
        C_RST   = 3'd0,
        C_MCHK  = 3'd1,
        C_IABR  = 3'd2,
        C_TRACE = 3'd3,
        C_EXT   = 3'd4,
        C_SMI   = 3'd5,
        C_PMON  = 3'd6,
        C_DEC   = 3'd7
    } cause_e;

    localparam int NUM_CAUSE = 8;

    function automatic logic [31:0] cause_vector(input cause_e c);
        logic [31:0] v;
        unique case (c)
            C_RST:   v = 32'h0000_0100;
            C_MCHK:  v = 32'h0000_0200;
            C_IABR:  v = 32'h0000_1300;
            C_TRACE: v = 32'h0000_0D00;
            C_EXT:   v = 32'h0000_0500;
            C_SMI:   v = 32'h0000_1400;
            C_PMON:  v = 32'h0000_0F00;
            C_DEC:   v = 32'h0000_0900;
            default: v = 32'h0000_0100;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/exc_dec_track.sv
module exc_dec_track (
    input  logic clk,
    input  logic rst_n,
    input  logic dec_msb,
    input  logic clr,
    output logic rise,
    output logic pend
);
    logic msb_q;

    assign rise = dec_msb & ~msb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msb_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            msb_q <= dec_msb;
            // A new edge wins over a clear in the same cycle.
            pend  <= rise | (pend & ~clr);
        end
    end
endmodule

// File: rtl/exc_iabr_match.sv
module exc_iabr_match #(
    parameter int EA_W  = 32,
    parameter int CMP_W = 30
) (
    input  logic [CMP_W-1:0] iabr_addr,
    input  logic             iabr_te,
    input  logic             iabr_en,
    input  logic             msr_ir,
    input  logic [EA_W-1:0]  next_ea,
    output logic             hit
);
    localparam int TOP = EA_W - 1;

    logic [CMP_W-1:0] ea_hi;
    assign ea_hi = next_ea[TOP -: CMP_W];
    assign hit   = iabr_en & (iabr_te == msr_ir) & (ea_hi == iabr_addr);
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]         req,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IDX_W = $clog2(N);

    logic [N-1:0] first;

    // first[i] is set when req[i] is the lowest-index request.
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_first
            if (g == 0) begin : g_lead
                assign first[g] = req[g];
            end else begin : g_rest
                assign first[g] = req[g] & ~(|req[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx = IDX_W'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_pkg::*;
#(
    parameter int EA_W  = 32,
    parameter int CMP_W = 30,
    parameter int PAR_W = 3,
    parameter int VEC_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hard_rst_req,
    input  logic             soft_rst_req,
    input  logic             por_req,
    input  logic             dbus_tea,
    input  logic             mchk_pin,
    input  logic [PAR_W-1:0] parity_err,
    input  logic             ext_int_pin,
    input  logic             smi_pin,
    input  logic             msr_ee,
    input  logic             msr_me,
    input  logic             msr_se,
    input  logic             msr_be,
    input  logic             msr_ir,
    input  logic             branch_done,
    input  logic             pmon_limit_hit,
    input  logic             pmon_int_en,
    input  logic             dec_msb,
    input  logic [CMP_W-1:0] iabr_addr,
    input  logic             iabr_te,
    input  logic             iabr_en,
    input  logic [EA_W-1:0]  next_ea,
    input  logic             exc_ack,
    output logic             exc_take,
    output logic [VEC_W-1:0] exc_vector
);
    localparam int NSRC  = NUM_CAUSE;
    localparam int IDX_W = $clog2(NSRC);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAKE = 2'd1,
        ST_HOLD = 2'd2
    } state_e;

    state_e           state_q, state_d;
    logic             dec_rise, dec_pend, dec_clr, iabr_hit;
    logic [NSRC-1:0]  req;
    logic             req_any;
    logic [IDX_W-1:0] req_idx;
    cause_e           cause_q;
    logic [VEC_W-1:0] vec_q;
    logic [31:0]      vec_full;

    exc_dec_track u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec_msb (dec_msb),
        .clr     (dec_clr),
        .rise    (dec_rise),
        .pend    (dec_pend)
    );

    exc_iabr_match #(.EA_W(EA_W), .CMP_W(CMP_W)) u_iabr (
        .iabr_addr (iabr_addr),
        .iabr_te   (iabr_te),
        .iabr_en   (iabr_en),
        .msr_ir    (msr_ir),
        .next_ea   (next_ea),
        .hit       (iabr_hit)
    );

    // Each source is gated by its own enable condition.
    always_comb begin
        req          = '0;
        req[C_RST]   = hard_rst_req | soft_rst_req | por_req;
        req[C_MCHK]  = msr_me & (dbus_tea | mchk_pin | (|parity_err));
        req[C_IABR]  = iabr_hit;
        req[C_TRACE] = msr_se | (branch_done & msr_be);
        req[C_EXT]   = msr_ee & ext_int_pin;
        req[C_SMI]   = msr_ee & smi_pin;
        req[C_PMON]  = pmon_limit_hit & pmon_int_en;
        req[C_DEC]   = msr_ee & (dec_pend | dec_rise);
    end

    exc_prio_pick #(.N(NSRC)) u_pick (
        .req (req),
        .any (req_any),
        .idx (req_idx)
    );

    assign vec_full = cause_vector(cause_e'(req_idx));
    assign dec_clr  = (state_q != ST_IDLE) && exc_ack && (cause_q == C_DEC);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_any) state_d = ST_TAKE;
            ST_TAKE: state_d = exc_ack ? ST_IDLE : ST_HOLD;
            ST_HOLD: if (exc_ack) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= C_RST;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_any) begin
                cause_q <= cause_e'(req_idx);
                vec_q   <= vec_full[VEC_W-1:0];
            end
        end
    end

    always_comb begin
        exc_take   = (state_q == ST_TAKE);
        exc_vector = vec_q;
    end
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
    parameter int EA_W  = 32,
    parameter int CMP_W = 30,
    parameter int PAR_W = 3,
    parameter int VEC_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hard_rst_req,
    input logic             soft_rst_req,
    input logic             por_req,
    input logic             msr_ee,
    input logic             msr_me,
    input logic             msr_ir,
    input logic             iabr_te,
    input logic             iabr_en,
    input logic             exc_take,
    input logic [VEC_W-1:0] exc_vector
);
    localparam logic [VEC_W-1:0] V_RST  = VEC_W'(32'h0100);
    localparam logic [VEC_W-1:0] V_MCHK = VEC_W'(32'h0200);
    localparam logic [VEC_W-1:0] V_EXT  = VEC_W'(32'h0500);
    localparam logic [VEC_W-1:0] V_SMI  = VEC_W'(32'h1400);
    localparam logic [VEC_W-1:0] V_IABR = VEC_W'(32'h1300);
    localparam logic [VEC_W-1:0] V_FP   = VEC_W'(32'h0E00);

    p_reset_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take && $past(hard_rst_req | soft_rst_req | por_req) |-> exc_vector == V_RST);

    p_mchk_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take && exc_vector == V_MCHK |-> $past(msr_me));

    p_ext_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take && exc_vector == V_EXT |-> $past(msr_ee));

    p_smi_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take && exc_vector == V_SMI |-> $past(msr_ee));

    p_iabr_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take && exc_vector == V_IABR |-> $past(iabr_en && (iabr_te == msr_ir)));

    p_take_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> !exc_take);

    p_vec_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> $stable(exc_vector));

    p_no_fp_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> exc_vector != V_FP);
endmodule

bind exc_vector_unit exc_vector_unit_chk #(
    .EA_W(EA_W), .CMP_W(CMP_W), .PAR_W(PAR_W), .VEC_W(VEC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hard_rst_req (hard_rst_req),
    .soft_rst_req (soft_rst_req),
    .por_req      (por_req),
    .msr_ee       (msr_ee),
    .msr_me       (msr_me),
    .msr_ir       (msr_ir),
    .iabr_te      (iabr_te),
    .iabr_en      (iabr_en),
    .exc_take     (exc_take),
    .exc_vector   (exc_vector)
);

// File: tb/exc_vector_unit_bench.sv
module exc_vector_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hard_rst_req, soft_rst_req, por_req, dbus_tea, mchk_pin;
    logic [2:0]  parity_err;
    logic        ext_int_pin, smi_pin, msr_ee, msr_me, msr_se, msr_be, msr_ir;
    logic        branch_done, pmon_limit_hit, pmon_int_en, dec_msb;
    logic [29:0] iabr_addr;
    logic        iabr_te, iabr_en;
    logic [31:0] next_ea;
    logic        exc_ack;
    logic        exc_take;
    logic [19:0] exc_vector;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_vector_unit u_exc_vector_unit (.*);

    // Stimulus bit positions
    localparam logic [17:0] S_HARD = 18'h1 << 0;
    localparam logic [17:0] S_SOFT = 18'h1 << 1;
    localparam logic [17:0] S_POR  = 18'h1 << 2;
    localparam logic [17:0] S_TEA  = 18'h1 << 3;
    localparam logic [17:0] S_MCP  = 18'h1 << 4;
    localparam logic [17:0] S_PA   = 18'h1 << 5;
    localparam logic [17:0] S_PD   = 18'h1 << 6;
    localparam logic [17:0] S_PL2  = 18'h1 << 7;
    localparam logic [17:0] S_INT  = 18'h1 << 8;
    localparam logic [17:0] S_SMI  = 18'h1 << 9;
    localparam logic [17:0] S_PMH  = 18'h1 << 10;
    localparam logic [17:0] S_PME  = 18'h1 << 11;
    localparam logic [17:0] S_SE   = 18'h1 << 12;
    localparam logic [17:0] S_BE   = 18'h1 << 13;
    localparam logic [17:0] S_BR   = 18'h1 << 14;
    localparam logic [17:0] S_EE   = 18'h1 << 15;
    localparam logic [17:0] S_ME   = 18'h1 << 16;
    localparam logic [17:0] S_IR   = 18'h1 << 17;

    // Row: {req number[3:0], stimulus[17:0], take expected, vector[19:0]}
    localparam int NROWS = 22;
    localparam logic [42:0] TBL [NROWS] = '{
        {4'd1,  S_HARD,                          1'b1, 20'h00100}, // R1
        {4'd1,  S_SOFT,                          1'b1, 20'h00100}, // R1
        {4'd1,  S_POR,                           1'b1, 20'h00100}, // R1
        {4'd2,  S_TEA | S_ME,                    1'b1, 20'h00200}, // R2
        {4'd2,  S_MCP | S_ME,                    1'b1, 20'h00200}, // R2
        {4'd2,  S_PA | S_ME,                     1'b1, 20'h00200}, // R2
        {4'd2,  S_PL2 | S_ME,                    1'b1, 20'h00200}, // R2
        {4'd2,  S_TEA | S_MCP | S_PD,            1'b0, 20'h00000}, // R2 gated
        {4'd3,  S_INT | S_EE,                    1'b1, 20'h00500}, // R3
        {4'd3,  S_INT,                           1'b0, 20'h00000}, // R3 gated
        {4'd4,  S_SMI | S_EE,                    1'b1, 20'h01400}, // R4
        {4'd4,  S_SMI,                           1'b0, 20'h00000}, // R4 gated
        {4'd7,  S_PMH | S_PME,                   1'b1, 20'h00F00}, // R7
        {4'd7,  S_PMH,                           1'b0, 20'h00000}, // R7 gated
        {4'd9,  S_SE,                            1'b1, 20'h00D00}, // R9
        {4'd9,  S_BE | S_BR,                     1'b1, 20'h00D00}, // R9
        {4'd9,  S_BR,                            1'b0, 20'h00000}, // R9 gated
        {4'd10, S_INT | S_SMI | S_PMH | S_PME | S_EE, 1'b1, 20'h00500}, // R10
        {4'd10, S_SMI | S_PMH | S_PME | S_EE,    1'b1, 20'h01400}, // R10
        {4'd10, S_HARD | S_TEA | S_ME | S_INT | S_EE, 1'b1, 20'h00100}, // R10
        {4'd10, S_TEA | S_ME | S_SE | S_INT | S_EE,   1'b1, 20'h00200}, // R10
        {4'd10, S_SE | S_INT | S_EE,             1'b1, 20'h00D00}  // R10
    };

    task automatic set_stim(input logic [17:0] s);
        hard_rst_req   = s[0];
        soft_rst_req   = s[1];
        por_req        = s[2];
        dbus_tea       = s[3];
        mchk_pin       = s[4];
        parity_err     = s[7:5];
        ext_int_pin    = s[8];
        smi_pin        = s[9];
        pmon_limit_hit = s[10];
        pmon_int_en    = s[11];
        msr_se         = s[12];
        msr_be         = s[13];
        branch_done    = s[14];
        msr_ee         = s[15];
        msr_me         = s[16];
        msr_ir         = s[17];
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic expect_take(input string req, input logic [19:0] vec);
        check(req, "take", 32'(exc_take), 32'd1);
        check(req, "vector", 32'(exc_vector), 32'(vec));
    endtask

    task automatic ack_cycle();
        exc_ack = 1'b1;
        @(negedge clk);
        exc_ack = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        set_stim('0);
        dec_msb   = 1'b0;
        iabr_addr = '0;
        iabr_te   = 1'b0;
        iabr_en   = 1'b0;
        next_ea   = '0;
        exc_ack   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12", "reset take", 32'(exc_take), 32'd0);
        check("R12", "reset vector", 32'(exc_vector), 32'd0);

        for (int r = 0; r < NROWS; r++) begin
            string tag;
            tag = $sformatf("R%0d row%0d", TBL[r][42:39], r);
            set_stim(TBL[r][38:21]);
            @(negedge clk);
            check(tag, "take", 32'(exc_take), 32'(TBL[r][20]));
            if (TBL[r][20]) check(tag, "vector", 32'(exc_vector), 32'(TBL[r][19:0]));
            set_stim('0);
            ack_cycle();
            check(tag, "after ack", 32'(exc_take), 32'd0);
        end

        // R11: single pulse, vector held, no retake before ack
        set_stim(S_INT | S_EE);
        @(negedge clk);
        expect_take("R11", 20'h00500);
        set_stim(S_INT | S_SMI | S_EE);
        @(negedge clk);
        check("R11", "pulse ends", 32'(exc_take), 32'd0);
        check("R11", "vector held", 32'(exc_vector), 32'h00500);
        @(negedge clk);
        check("R11", "no retake", 32'(exc_take), 32'd0);
        set_stim('0);
        ack_cycle();

        // R5: edge taken with EE, level high gives nothing more
        set_stim(S_EE);
        dec_msb = 1'b1;
        @(negedge clk);
        expect_take("R5", 20'h00900);
        ack_cycle();
        repeat (3) begin
            @(negedge clk);
            check("R5", "level no take", 32'(exc_take), 32'd0);
        end
        dec_msb = 1'b0;
        set_stim('0);
        @(negedge clk);

        // R6: edge with EE low stays pending
        dec_msb = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R6", "pending no take", 32'(exc_take), 32'd0);
        end
        dec_msb = 1'b0;
        set_stim(S_EE);
        @(negedge clk);
        expect_take("R6", 20'h00900);
        set_stim('0);
        ack_cycle();

        // R12: another source's ack leaves decrementer pending
        dec_msb = 1'b1;
        @(negedge clk);
        dec_msb = 1'b0;
        set_stim(S_INT | S_EE);
        @(negedge clk);
        expect_take("R12", 20'h00500);
        set_stim(S_EE);
        ack_cycle();
        check("R12", "idle after ack", 32'(exc_take), 32'd0);
        @(negedge clk);
        expect_take("R12", 20'h00900);
        set_stim('0);
        ack_cycle();
        @(negedge clk);
        check("R12", "dec cleared", 32'(exc_take), 32'd0);

        // R8: breakpoint match, low bits ignored
        iabr_addr = 30'h2345_6789;
        next_ea   = {30'h2345_6789, 2'b11};
        iabr_te   = 1'b1;
        iabr_en   = 1'b1;
        set_stim(S_IR);
        @(negedge clk);
        expect_take("R8", 20'h01300);
        set_stim('0);
        ack_cycle();
        check("R8", "tag mismatch", 32'(exc_take), 32'd0);
        set_stim(S_IR);
        next_ea = {30'h2345_6788, 2'b00};
        @(negedge clk);
        check("R8", "addr mismatch", 32'(exc_take), 32'd0);
        next_ea = {30'h2345_6789, 2'b00};
        iabr_en = 1'b0;
        @(negedge clk);
        check("R8", "disabled", 32'(exc_take), 32'd0);

        // R10: breakpoint over trace, machine check over breakpoint
        iabr_en = 1'b1;
        set_stim(S_IR | S_SE);
        @(negedge clk);
        expect_take("R10", 20'h01300);
        set_stim(S_IR | S_TEA | S_ME);
        ack_cycle();
        @(negedge clk);
        expect_take("R10", 20'h00200);
        set_stim('0);
        iabr_en = 1'b0;
        ack_cycle();

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule